// File: doc/BRIEF.md
# In-Place Radix-2 FFT Address Sequencer

This block drives a single shared radix-2 butterfly through a complete 1024-point decimation-in-time transform that is computed in place. After a start pulse it walks through all ten stages, and within each stage through all 512 butterflies. It issues one butterfly per cycle. For each issue it presents the two operand addresses for the data RAM and the twiddle-factor ROM address. Eleven cycles later, when the butterfly's arithmetic pipeline returns the results, it presents the same two addresses again as a write strobe. When the last result has been written back it pulses `done`.

Operand data must already be in the RAM in bit-reversed order before the start pulse. The results are then left in natural order. The butterfly arithmetic, the RAM, the ROM contents and the loading of input data are not part of this block. No stream handshake exists here. The butterfly must accept one issue on every cycle in which `issue_valid` is high, and it must return its results after exactly the fixed latency. Because nothing can apply back-pressure, the whole transform occupies a fixed 5131 cycles.

Top module: `fft_inplace_seq`

## Requirements
- R1: After reset, and while reset (`rst_n` low) is held, `busy`, `done`, `issue_valid` and `we` are all low.
- R2: A `start` pulse sampled while `busy` is low makes `issue_valid` high in the very next cycle. That cycle is issue 0.
- R3: Issue number t belongs to stage s = t/512 and butterfly j = t mod 512. For that issue, `raddr_a` = (j >> s)·2^(s+1) + (j mod 2^s) and `raddr_b` = `raddr_a` + 2^s.
- R4: For issue t, `rom_addr` = (j mod 2^s) · 2^(9−s).
- R5: `issue_valid` is high for exactly 5120 consecutive cycles (issues 0 through 5119) and is low otherwise. It is never high while `busy` is low.
- R6: `we` is high exactly 11 cycles after each issue. In that cycle `waddr_a` and `waddr_b` equal the `raddr_a` and `raddr_b` of that issue.
- R7: `done` is a single-cycle pulse in cycle 5131 counted from issue 0. `busy` is high from issue 0 through cycle 5130 and low in the `done` cycle.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The issue sequence, the write-backs and the `done` timing are unchanged.
- R9: No issue reads an address whose write-back from an earlier issue is still pending. A write is pending from its issue up to and including the cycle of its `we`.
- R10: Asserting reset in the middle of a transform stops it at once. After release the block stays idle until the next `start`, and that `start` begins again from stage 0, butterfly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a transform when idle |
| busy | output | 1 | Transform in progress (issuing or draining) |
| done | output | 1 | One-cycle pulse after the final write-back |
| issue_valid | output | 1 | A butterfly is issued this cycle |
| raddr_a | output | 10 | Upper-leg operand read address |
| raddr_b | output | 10 | Lower-leg operand read address |
| rom_addr | output | 9 | Twiddle-factor ROM index |
| we | output | 1 | Write-back strobe for both result addresses |
| waddr_a | output | 10 | Upper-leg result write address |
| waddr_b | output | 10 | Lower-leg result write address |

## Verification
The hardest situation to reach is a stage boundary. There the first reads of the new stage happen while the last eleven writes of the old stage are still in flight. A read-after-write hazard can only be seen if the bench tracks every pending write. The bench therefore keeps a per-address count of outstanding writes over a full 5131-cycle transform. It checks every issued read against that count before the count is decremented for writes that complete in the same cycle. It also aborts a transform with a mid-run reset, pokes `start` while busy, and launches a second transform in the very cycle `done` pulses.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

  // Lower-leg-free (upper) operand address of butterfly j in stage s:
  // insert a zero at bit position s of j.
  function automatic int unsigned upper_leg_addr(input int unsigned s, input int unsigned j);
    int unsigned span;
    span = 32'd1 << s;
    return ((j >> s) << (s + 1)) + (j & (span - 1));
  endfunction

endpackage

// File: rtl/fft_seq_ctr.sv
module fft_seq_ctr #(
  parameter int LOG2N = 10,
  localparam int STG_W = $clog2(LOG2N),
  localparam int IDX_W = LOG2N - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             run,
  output logic [STG_W-1:0] stage,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [STG_W-1:0] STG_LAST = STG_W'(LOG2N - 1);

  logic idx_wrap;
  assign idx_wrap = &idx;
  assign last     = run && idx_wrap && (stage == STG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      stage <= '0;
      idx   <= '0;
    end else if (!run) begin
      if (go) begin
        run   <= 1'b1;
        stage <= '0;
        idx   <= '0;
      end
    end else begin
      idx <= idx + 1'b1;
      if (idx_wrap) begin
        if (stage == STG_LAST) begin
          run   <= 1'b0;
          stage <= '0;
        end else begin
          stage <= stage + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fft_seq_rd_addr.sv
module fft_seq_rd_addr #(
  parameter int LOG2N = 10,
  localparam int STG_W = $clog2(LOG2N),
  localparam int IDX_W = LOG2N - 1,
  localparam int AW    = LOG2N,
  localparam int TW_W  = LOG2N - 1
) (
  input  logic [STG_W-1:0] stage,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr_a,
  output logic [AW-1:0]    addr_b,
  output logic [TW_W-1:0]  tw_addr
);
  localparam logic [STG_W-1:0] TW_TOP = STG_W'(LOG2N - 1);

  logic [AW-1:0]    span;
  logic [AW-1:0]    j_ext;
  logic [AW-1:0]    offset;
  logic [AW-1:0]    group;
  logic [STG_W-1:0] tw_shift;

  always_comb begin
    span     = AW'(1) << stage;
    j_ext    = AW'(idx);
    offset   = j_ext & (span - 1'b1);
    group    = j_ext >> stage;
    addr_a   = ((group << stage) << 1) | offset;
    addr_b   = addr_a | span;
    tw_shift = TW_TOP - stage;
    tw_addr  = TW_W'(offset) << tw_shift;
  end
endmodule

// File: rtl/fft_seq_wb_pipe.sv
module fft_seq_wb_pipe #(
  parameter int LAT = 11,
  parameter int AW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [AW-1:0] in_a,
  input  logic [AW-1:0] in_b,
  output logic          out_valid,
  output logic          out_last,
  output logic [AW-1:0] out_a,
  output logic [AW-1:0] out_b,
  output logic          any_valid
);
  logic [LAT-1:0] v_q;
  logic [LAT-1:0] l_q;
  logic [AW-1:0]  a_q [LAT];
  logic [AW-1:0]  b_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      l_q <= '0;
      for (int i = 0; i < LAT; i++) begin
        a_q[i] <= '0;
        b_q[i] <= '0;
      end
    end else begin
      v_q[0] <= in_valid;
      l_q[0] <= in_valid & in_last;
      a_q[0] <= in_a;
      b_q[0] <= in_b;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        l_q[i] <= l_q[i-1];
        a_q[i] <= a_q[i-1];
        b_q[i] <= b_q[i-1];
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_last  = l_q[LAT-1];
  assign out_a     = a_q[LAT-1];
  assign out_b     = b_q[LAT-1];
  assign any_valid = |v_q;
endmodule

// File: rtl/fft_inplace_seq.sv
module fft_inplace_seq #(
  parameter int LOG2N = 10,
  parameter int LAT   = 11,
  localparam int AW    = LOG2N,
  localparam int TW_W  = LOG2N - 1,
  localparam int STG_W = $clog2(LOG2N),
  localparam int IDX_W = LOG2N - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            issue_valid,
  output logic [AW-1:0]   raddr_a,
  output logic [AW-1:0]   raddr_b,
  output logic [TW_W-1:0] rom_addr,
  output logic            we,
  output logic [AW-1:0]   waddr_a,
  output logic [AW-1:0]   waddr_b
);
  logic             run;
  logic             last_issue;
  logic [STG_W-1:0] stage;
  logic [IDX_W-1:0] idx;
  logic             wb_last;
  logic             wb_any;
  logic             go;

  assign go = start & ~busy;

  fft_seq_ctr #(.LOG2N(LOG2N)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .run   (run),
    .stage (stage),
    .idx   (idx),
    .last  (last_issue)
  );

  fft_seq_rd_addr #(.LOG2N(LOG2N)) u_rd (
    .stage   (stage),
    .idx     (idx),
    .addr_a  (raddr_a),
    .addr_b  (raddr_b),
    .tw_addr (rom_addr)
  );

  fft_seq_wb_pipe #(.LAT(LAT), .AW(AW)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (run),
    .in_last   (last_issue),
    .in_a      (raddr_a),
    .in_b      (raddr_b),
    .out_valid (we),
    .out_last  (wb_last),
    .out_a     (waddr_a),
    .out_b     (waddr_b),
    .any_valid (wb_any)
  );

  assign issue_valid = run;
  assign busy        = run | wb_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= we & wb_last;
  end
endmodule

// File: rtl/fft_inplace_seq_chk.sv
module fft_inplace_seq_chk #(
  parameter int LOG2N = 10,
  localparam int AW   = LOG2N
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          issue_valid,
  input logic [AW-1:0] raddr_a,
  input logic [AW-1:0] raddr_b,
  input logic          we
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!issue_valid && !we));

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  pair_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ($countones(raddr_a ^ raddr_b) == 1 && raddr_a < raddr_b));

  // R5
  issue_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> busy);

  // R6
  wb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind fft_inplace_seq fft_inplace_seq_chk #(.LOG2N(LOG2N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .issue_valid (issue_valid),
  .raddr_a     (raddr_a),
  .raddr_b     (raddr_b),
  .we          (we)
);

// File: tb/test_fft_inplace_seq.sv
module test_fft_inplace_seq;
  localparam int NPT    = 1024;
  localparam int HALFN  = 512;
  localparam int NSTG   = 10;
  localparam int NISSUE = NSTG * HALFN;
  localparam int PLAT   = 11;
  localparam int TOTAL  = NISSUE + PLAT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, issue_valid, we;
  logic [9:0] raddr_a, raddr_b, waddr_a, waddr_b;
  logic [8:0] rom_addr;

  int n_chk = 0;
  int n_bad = 0;
  int pend [NPT];

  always #4 clk = ~clk;

  fft_inplace_seq i_fft_inplace_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .issue_valid(issue_valid), .raddr_a(raddr_a), .raddr_b(raddr_b),
    .rom_addr(rom_addr), .we(we), .waddr_a(waddr_a), .waddr_b(waddr_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_a(input int t);
    int s = t / HALFN;
    int j = t % HALFN;
    return ((j >> s) << (s + 1)) + (j & ((1 << s) - 1));
  endfunction

  function automatic int exp_b(input int t);
    return exp_a(t) + (1 << (t / HALFN));
  endfunction

  function automatic int exp_rom(input int t);
    int s = t / HALFN;
    int j = t % HALFN;
    return (j & ((1 << s) - 1)) << (NSTG - 1 - s);
  endfunction

  task automatic check_idle(input string req);
    chk(busy == 1'b0, req, "busy", busy, 0);
    chk(done == 1'b0, req, "done", done, 0);
    chk(issue_valid == 1'b0, req, "issue_valid", issue_valid, 0);
    chk(we == 1'b0, req, "we", we, 0);
  endtask

  // Full transform; called at a negedge. poke_at >= 0 re-pulses start while busy (R8).
  task automatic run_job(input int poke_at);
    for (int i = 0; i < NPT; i++) pend[i] = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= TOTAL; k++) begin
      bit eiv = (k < NISSUE);
      bit ewe = (k >= PLAT) && (k < TOTAL);
      chk(issue_valid == eiv, (k == 0) ? "R2" : "R5", "issue_valid", issue_valid, eiv);
      if (eiv && issue_valid) begin
        chk(raddr_a == exp_a(k), "R3", "raddr_a", raddr_a, exp_a(k));
        chk(raddr_b == exp_b(k), "R3", "raddr_b", raddr_b, exp_b(k));
        chk(rom_addr == exp_rom(k), "R4", "rom_addr", rom_addr, exp_rom(k));
      end
      if (issue_valid) begin
        chk(pend[raddr_a] == 0 && pend[raddr_b] == 0, "R9", "pending writes on read",
            pend[raddr_a] + pend[raddr_b], 0);
      end
      chk(we == ewe, "R6", "we", we, ewe);
      if (ewe && we) begin
        chk(waddr_a == exp_a(k - PLAT), "R6", "waddr_a", waddr_a, exp_a(k - PLAT));
        chk(waddr_b == exp_b(k - PLAT), "R6", "waddr_b", waddr_b, exp_b(k - PLAT));
      end
      if (we) begin
        pend[waddr_a]--;
        pend[waddr_b]--;
      end
      if (issue_valid) begin
        pend[raddr_a]++;
        pend[raddr_b]++;
      end
      chk(done == (k == TOTAL), "R7", "done", done, k == TOTAL);
      chk(busy == (k < TOTAL), "R7", "busy", busy, k < TOTAL);
      if (k == TOTAL) break;
      start = (k == poke_at);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_plain_run();
    run_job(-1);
    @(negedge clk);
    check_idle("R7");
  endtask

  task automatic t_start_while_busy();
    run_job(2500);
    @(negedge clk);
    check_idle("R8");
  endtask

  task automatic t_back_to_back();
    run_job(-1);
    run_job(-1);
    @(negedge clk);
    check_idle("R2");
  endtask

  task automatic t_reset_abort();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (700) @(negedge clk);
    chk(issue_valid == 1'b1, "R10", "issue_valid before abort", issue_valid, 1);
    rst_n = 1'b0;
    #1;
    check_idle("R10");
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_idle("R10");
    run_job(-1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_plain_run();
    t_start_while_busy();
    t_back_to_back();
    t_reset_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule